// File: doc/BRIEF.md
# Receive Address Filter with Descriptor DMA

This block takes incoming Ethernet frames as a byte stream, holds each frame whole in a local buffer, and decides when the last byte has arrived whether the frame is kept. A frame is kept only when reception is enabled at both the MAC level and the DMA level, its length fits the programmed limit and the local buffer, and its destination address passes the broadcast, multicast and unicast filter. The broadcast and multicast enables come from a reject register and an accept-override register. The accept-override register wins.

A kept frame is copied as 32-bit words into the buffer that the current receive descriptor points to. The descriptor is then closed with the frame length, and the receive status count and received flag are updated. The current descriptor pointer then follows the chain. If the current descriptor is still owned by software, the frame is not dropped quietly. Instead, receive DMA is switched off and an overflow flag is raised. An interrupt line combines the receive status with transmit status bits supplied from outside, under an 8-bit mask.

Registers are written through a simple select/data port. The status, the DMA enable and the interrupt line are visible as outputs. Memory is reached through one word-aligned port whose read data returns one cycle after the request.

Top module: `rx_filter_dma`

## Requirements
- R1: After reset, `rx_status` is zero, `rx_dma_en` and `irq` are low, and no memory request is made. The MAC receive enable is off. The length limit resets to 0x600, and the accept-override register resets with both bits set.
- R2: A frame is kept only if MAC config (select 0) bit 2 is set and receive DMA (select 6, bit 0) is enabled when the frame's last byte has been taken. In every other case no memory write happens and the status does not change.
- R3: A frame is dropped if it is shorter than 6 bytes, longer than select 1 bits 15:0, or longer than the local buffer of 4*BUF_WORDS bytes. A frame whose length equals the limit is kept.
- R4: Broadcast is accepted if select 3 bit 9 is set. Otherwise it is rejected if select 2 bit 9 is set, and accepted if neither is set. Multicast follows the same rule with bit 8 of the same two registers.
- R5: A destination of six 0xFF bytes is broadcast. Any other destination whose first byte has bit 0 set is multicast. Every other frame is kept only if its destination equals the station address. The station address is made of select 4 bits 31:24, 23:16, 15:8 and 7:0 as bytes 0 to 3, then select 5 bits 31:24 and 23:16 as bytes 4 and 5.
- R6: A descriptor is three words: the buffer address at +0, the size word at +4 (bit 31 set means empty and owned by the block), and the next pointer at +8. A kept frame going to an empty descriptor is handled as follows:
  - Frame byte n lands in byte lane n%4 (bits 8*(n%4)+7 down to 8*(n%4)) of word n/4 of the buffer. Unused lanes of the last word are zero.
  - The size word becomes the length masked to 11 bits, with bit 31 clear.
  - Status bits 23:16 increase by one, status bit 0 is set, and the pointer moves to the next pointer.
- R7: If the current descriptor's size word has bit 31 clear, nothing is written to memory. `rx_dma_en` drops, status bit 2 (overflow) is set, and the count is unchanged.
- R8: Writing select 6 with bit 0 set enables receive DMA and loads the current pointer from select 7 with its low two bits cleared. Writing it with bit 0 clear disables receive DMA.
- R9: Writing select 8 with bit 2 set clears overflow. Writing it with bit 0 set decrements the count, and clears status bit 0 when the count reaches zero.
- R10: `irq` is high exactly when select 9 bits 7:0, ANDed with {rx_status[3:0], tx_status}, is nonzero.
- R11: A dropped frame writes no memory and leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 32 | Register write data |
| tx_status | input | 4 | Transmit status bits for the interrupt |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| rx_dma_en | output | 1 | Receive DMA enabled |
| rx_status | output | 32 | Count in 23:16, overflow in 2, received in 0 |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the override order of the two filter registers. A design that let the reject bit win would lose broadcasts that software had forced on. It sends frames one past the limit, exactly at the limit, and one past the local buffer. A wrong comparison shows up as an extra or a missing descriptor write. It lets the ring wrap onto a descriptor still owned by software. A design that dropped quietly, or that wrote the buffer anyway, would leave DMA enabled or change a buffer word that is already filled. It also checks that a rejected frame on a full ring raises no overflow, and that the count decrement clears the received flag only on the last acknowledge.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   localparam logic [3:0] SEL_MAC   = 4'd0;
   localparam logic [3:0] SEL_MAXL  = 4'd1;
   localparam logic [3:0] SEL_REJ   = 4'd2;
   localparam logic [3:0] SEL_ACC   = 4'd3;
   localparam logic [3:0] SEL_STA_A = 4'd4;
   localparam logic [3:0] SEL_STA_B = 4'd5;
   localparam logic [3:0] SEL_DCTL  = 4'd6;
   localparam logic [3:0] SEL_DBASE = 4'd7;
   localparam logic [3:0] SEL_ACK   = 4'd8;
   localparam logic [3:0] SEL_MASK  = 4'd9;

   localparam int DEST_BYTES = 6;
   localparam int EMPTY_BIT  = 31;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SZ, ST_CHK, ST_BA, ST_NX, ST_COPY, ST_DESC
   } rxf_state_t;
endpackage

// File: rtl/rxf_addr_match.sv
module rxf_addr_match (
   input  logic [47:0] dest,
   input  logic [47:0] station,
   input  logic        rej_bc,
   input  logic        rej_mc,
   input  logic        acc_bc,
   input  logic        acc_mc,
   output logic        pass
);
   logic bc_ok, mc_ok, is_bc, is_mc;

   // accept-override beats reject; neither set means accept
   assign bc_ok = acc_bc | ~rej_bc;
   assign mc_ok = acc_mc | ~rej_mc;
   assign is_bc = &dest;
   assign is_mc = dest[40];

   always_comb begin
      if (is_bc)      pass = bc_ok;
      else if (is_mc) pass = mc_ok;
      else            pass = (dest == station);
   end
endmodule

// File: rtl/rxf_frame_buf.sv
module rxf_frame_buf #(
   parameter int BUF_WORDS = 64,
   parameter int LEN_W     = 16,
   localparam int IDX_W     = $clog2(BUF_WORDS),
   localparam int BUF_BYTES = BUF_WORDS * 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   input  logic             in_last,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [31:0]      rd_word,
   output logic             done,
   output logic [LEN_W-1:0] flen,
   output logic [47:0]      dest
);
   generate
      if (BUF_WORDS < 2 || (1 << IDX_W) != BUF_WORDS)
         $error("BUF_WORDS must be a power of two of at least 2");
      if (LEN_W < IDX_W + 4)
         $error("LEN_W too narrow for the buffer");
   endgenerate

   logic [31:0]      store [BUF_WORDS];
   logic [LEN_W-1:0] len, len_inc;
   logic             take;
   logic [IDX_W-1:0] widx;
   logic [1:0]       lane;

   assign take    = in_valid & ~hold;
   assign len_inc = (&len) ? len : len + LEN_W'(1);
   assign widx    = len[IDX_W+1:2];
   assign lane    = len[1:0];
   assign rd_word = store[rd_idx];

   always_ff @(posedge clk) begin
      if (take && len < LEN_W'(BUF_BYTES)) begin
         if (lane == 2'd0) store[widx] <= {24'h0, in_data};
         else              store[widx][{lane, 3'b000} +: 8] <= in_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len  <= '0;
         flen <= '0;
         done <= 1'b0;
         dest <= '0;
      end else begin
         done <= take & in_last;
         if (take) begin
            for (int g = 0; g < rxf_pkg::DEST_BYTES; g++)
               if (len == LEN_W'(g)) dest[47-8*g -: 8] <= in_data;
            if (in_last) begin
               len  <= '0;
               flen <= len_inc;
            end else begin
               len <= len_inc;
            end
         end
      end
   end
endmodule

// File: rtl/rxf_desc_engine.sv
module rxf_desc_engine
   import rxf_pkg::*;
#(
   parameter int AW        = 32,
   parameter int BUF_WORDS = 64,
   parameter int LEN_W     = 16,
   localparam int IDX_W     = $clog2(BUF_WORDS),
   localparam int BUF_BYTES = BUF_WORDS * 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic [LEN_W-1:0] flen,
   input  logic             pass,
   input  logic             cfg_rx_en,
   input  logic [15:0]      max_len,
   input  logic             ctl_wr,
   input  logic             ctl_en,
   input  logic [AW-1:0]    base,
   input  logic             ack_wr,
   input  logic             ack_ovf,
   input  logic             ack_rcv,
   input  logic [31:0]      rd_word,
   output logic [IDX_W-1:0] rd_idx,
   output logic             busy,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic [31:0]      mem_rdata,
   output logic             dma_en,
   output logic [31:0]      status
);
   generate
      if (AW < 8 || AW > 32) $error("AW must lie in 8..32");
   endgenerate

   rxf_state_t       state;
   logic [AW-1:0]    cur, nxt, bufa;
   logic [IDX_W-1:0] idx;
   logic [LEN_W-1:0] len_q, nw_m1;
   logic [7:0]       cnt, cnt_nx;
   logic             ovf, rcv, keep, last_word, empty, inc, dec, ovf_evt;

   assign keep = done & cfg_rx_en & dma_en & pass
               & (flen >= LEN_W'(6))
               & (32'(flen) <= 32'(max_len))
               & (32'(flen) <= 32'(BUF_BYTES));
   assign nw_m1     = ((len_q + LEN_W'(3)) >> 2) - LEN_W'(1);
   assign last_word = (LEN_W'(idx) == nw_m1);
   assign empty     = mem_rdata[EMPTY_BIT];
   assign inc       = (state == ST_DESC);
   assign dec       = ack_wr & ack_rcv;
   assign ovf_evt   = (state == ST_CHK) & ~empty;
   assign cnt_nx    = cnt + {7'd0, inc} - {7'd0, dec};
   assign rd_idx    = idx;
   assign busy      = (state != ST_IDLE);
   assign status    = {8'h00, cnt, 13'h0, ovf, 1'b0, rcv};

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur;
      mem_wdata = '0;
      unique case (state)
         ST_SZ:  begin mem_req = 1'b1; mem_addr = cur + AW'(4); end
         ST_CHK: mem_req = empty;
         ST_BA:  begin mem_req = 1'b1; mem_addr = cur + AW'(8); end
         ST_COPY: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = bufa + AW'({idx, 2'b00});
            mem_wdata = rd_word;
         end
         ST_DESC: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur + AW'(4);
            mem_wdata = 32'(len_q) & 32'h0000_07FF;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cur    <= '0;
         nxt    <= '0;
         bufa   <= '0;
         idx    <= '0;
         len_q  <= '0;
         dma_en <= 1'b0;
         cnt    <= '0;
         ovf    <= 1'b0;
         rcv    <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (keep) begin state <= ST_SZ; len_q <= flen; end
            ST_SZ:   state <= ST_CHK;
            ST_CHK:  state <= empty ? ST_BA : ST_IDLE;
            ST_BA:   begin bufa <= mem_rdata[AW-1:0] & ~AW'(3); state <= ST_NX; end
            ST_NX:   begin
               nxt   <= mem_rdata[AW-1:0] & ~AW'(3);
               idx   <= '0;
               state <= ST_COPY;
            end
            ST_COPY: if (last_word) state <= ST_DESC; else idx <= idx + IDX_W'(1);
            ST_DESC: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase

         if (ctl_wr && ctl_en) cur <= base & ~AW'(3);
         else if (inc)         cur <= nxt;

         if (ovf_evt)     dma_en <= 1'b0;
         else if (ctl_wr) dma_en <= ctl_en;

         cnt <= cnt_nx;
         if (inc)                       rcv <= 1'b1;
         else if (dec && cnt_nx == '0)  rcv <= 1'b0;
         if (ovf_evt)                   ovf <= 1'b1;
         else if (ack_wr && ack_ovf)    ovf <= 1'b0;
      end
   end
endmodule

// File: rtl/rx_filter_dma.sv
module rx_filter_dma
   import rxf_pkg::*;
#(
   parameter int          AW           = 32,
   parameter int          BUF_WORDS    = 64,
   parameter int          LEN_W        = 16,
   parameter logic [15:0] MAXLEN_RESET = 16'h0600,
   localparam int IDX_W = $clog2(BUF_WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [7:0]    rx_data,
   input  logic          rx_last,
   input  logic          reg_we,
   input  logic [3:0]    reg_sel,
   input  logic [31:0]   reg_wdata,
   input  logic [3:0]    tx_status,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata,
   output logic          rx_dma_en,
   output logic [31:0]   rx_status,
   output logic          irq
);
   logic          mac_rx_en, rej_bc, rej_mc, acc_bc, acc_mc;
   logic [15:0]   max_len, sta_b;
   logic [31:0]   sta_a;
   logic [AW-1:0] base;
   logic [7:0]    irq_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mac_rx_en <= 1'b0;
         max_len   <= MAXLEN_RESET;
         rej_bc    <= 1'b0;
         rej_mc    <= 1'b0;
         acc_bc    <= 1'b1;
         acc_mc    <= 1'b1;
         sta_a     <= '0;
         sta_b     <= '0;
         base      <= '0;
         irq_mask  <= '0;
      end else if (reg_we) begin
         unique case (reg_sel)
            SEL_MAC:   mac_rx_en <= reg_wdata[2];
            SEL_MAXL:  max_len <= reg_wdata[15:0];
            SEL_REJ:   {rej_bc, rej_mc} <= reg_wdata[9:8];
            SEL_ACC:   {acc_bc, acc_mc} <= reg_wdata[9:8];
            SEL_STA_A: sta_a <= reg_wdata;
            SEL_STA_B: sta_b <= reg_wdata[31:16];
            SEL_DBASE: base <= reg_wdata[AW-1:0] & ~AW'(3);
            SEL_MASK:  irq_mask <= reg_wdata[7:0];
            default: ;
         endcase
      end
   end

   logic             done, busy, pass;
   logic [LEN_W-1:0] flen;
   logic [47:0]      dest;
   logic [IDX_W-1:0] rd_idx;
   logic [31:0]      rd_word;

   rxf_frame_buf #(.BUF_WORDS(BUF_WORDS), .LEN_W(LEN_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .hold(busy | done),
      .in_valid(rx_valid), .in_data(rx_data), .in_last(rx_last),
      .rd_idx(rd_idx), .rd_word(rd_word),
      .done(done), .flen(flen), .dest(dest)
   );

   rxf_addr_match u_match (
      .dest(dest), .station({sta_a, sta_b}),
      .rej_bc(rej_bc), .rej_mc(rej_mc), .acc_bc(acc_bc), .acc_mc(acc_mc),
      .pass(pass)
   );

   rxf_desc_engine #(.AW(AW), .BUF_WORDS(BUF_WORDS), .LEN_W(LEN_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .done(done), .flen(flen), .pass(pass),
      .cfg_rx_en(mac_rx_en), .max_len(max_len),
      .ctl_wr(reg_we && reg_sel == SEL_DCTL), .ctl_en(reg_wdata[0]), .base(base),
      .ack_wr(reg_we && reg_sel == SEL_ACK),
      .ack_ovf(reg_wdata[2]), .ack_rcv(reg_wdata[0]),
      .rd_word(rd_word), .rd_idx(rd_idx), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .dma_en(rx_dma_en), .status(rx_status)
   );

   assign irq = |(irq_mask & {rx_status[3:0], tx_status});
endmodule

// File: rtl/rx_filter_dma_chk.sv
module rx_filter_dma_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mem_req,
   input logic [1:0] addr_lo,
   input logic       rx_dma_en,
   input logic [7:0] cnt,
   input logic       ovf,
   input logic       rcv,
   input logic [7:0] irq_mask,
   input logic       irq
);
   assert_addr_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> addr_lo == 2'b00);

   assert_count_sets_rcv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == $past(cnt) + 8'd1) |-> rcv);

   assert_ovf_stops_dma_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> !rx_dma_en);

   assert_zero_clears_rcv_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == 8'd0 && $past(cnt) == 8'd1) |-> !rcv);

   assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mask == 8'h00) |-> !irq);
endmodule

bind rx_filter_dma rx_filter_dma_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .addr_lo(mem_addr[1:0]),
   .rx_dma_en(rx_dma_en), .cnt(rx_status[23:16]), .ovf(rx_status[2]),
   .rcv(rx_status[0]), .irq_mask(irq_mask), .irq(irq)
);

// File: tb/rx_filter_dma_tb_top.sv
`timescale 1ns/1ps
module rx_filter_dma_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0, rx_last = 1'b0, reg_we = 1'b0;
   logic [7:0]  rx_data = '0;
   logic [3:0]  reg_sel = '0, tx_status = '0;
   logic [31:0] reg_wdata = '0;
   logic        mem_req, mem_we, rx_dma_en, irq;
   logic [31:0] mem_addr, mem_wdata, rx_status;
   logic [31:0] mem_rdata = '0;
   logic [31:0] mem [1024];
   int          checks = 0, errors = 0, wr_cnt = 0;

   always #2 clk = ~clk;

   rx_filter_dma dut_i (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_last(rx_last), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .tx_status(tx_status), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .rx_dma_en(rx_dma_en), .rx_status(rx_status),
      .irq(irq)
   );

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            mem[mem_addr[11:2]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
         end else begin
            mem_rdata <= mem[mem_addr[11:2]];
         end
      end
   end

   localparam logic [47:0] STA   = 48'h02_11_22_33_44_55;
   localparam logic [47:0] OTHER = 48'h02_11_22_33_44_56;
   localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
   localparam logic [47:0] MCAST = 48'h01_00_5E_00_00_01;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [3:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   function automatic logic [7:0] fbyte(input logic [47:0] d, input logic [7:0] seed, input int i);
      if (i < 6) return d[47-8*i -: 8];
      return seed + 8'(i);
   endfunction

   task automatic send(input logic [47:0] d, input int len, input logic [7:0] seed);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_data = fbyte(d, seed, i); rx_last = (i == len - 1);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0;
      repeat (90) @(negedge clk);
   endtask

   function automatic logic [31:0] exp_word(input logic [47:0] d, input logic [7:0] seed,
                                            input int len, input int w);
      logic [31:0] r = '0;
      for (int k = 0; k < 4; k++)
         if (4*w + k < len) r[8*k +: 8] = fbyte(d, seed, 4*w + k);
      return r;
   endfunction

   task automatic check_buf(input string req, input int widx, input logic [47:0] d,
                            input logic [7:0] seed, input int len);
      logic [31:0] a = '0, e = '0;
      bit bad = 0;
      for (int w = 0; w < (len + 3) / 4; w++) begin
         if (!bad && mem[widx + w] !== exp_word(d, seed, len, w)) begin
            bad = 1; a = mem[widx + w]; e = exp_word(d, seed, len, w);
         end
      end
      check(req, a, e);
   endtask

   task automatic arm_ring();
      @(negedge clk);
      mem[10'h40] = 32'h400; mem[10'h41] = 32'h8000_0000; mem[10'h42] = 32'h110;
      mem[10'h44] = 32'h800; mem[10'h45] = 32'h8000_0000; mem[10'h46] = 32'h120;
      mem[10'h48] = 32'hC00; mem[10'h49] = 32'h8000_0000; mem[10'h4A] = 32'h100;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int w0;
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 status", rx_status, 32'h0);
      check("R1 dma_en", {31'h0, rx_dma_en}, 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);

      arm_ring();
      wreg(4'd4, 32'h0211_2233);
      wreg(4'd5, 32'h4455_0000);
      wreg(4'd7, 32'h0000_0103);
      wreg(4'd6, 32'h1);
      check("R8 dma_en", {31'h0, rx_dma_en}, 32'h1);

      // R2 MAC receive still off
      send(STA, 20, 8'h10);
      check("R2 off status", rx_status, 32'h0);
      check("R2 off writes", wr_cnt, 0);

      wreg(4'd0, 32'h4);
      send(STA, 20, 8'h10);
      check("R6 size word", mem[10'h41], 32'd20);
      check_buf("R6 buffer", 10'h100, STA, 8'h10, 20);
      check("R6 status", rx_status, 32'h0001_0001);
      check("R8 pointer base", wr_cnt, 6);
      w0 = wr_cnt;

      send(OTHER, 20, 8'h20);
      check("R5 mismatch status", rx_status, 32'h0001_0001);
      check("R11 mismatch writes", wr_cnt, w0);

      send(BCAST, 30, 8'h40);
      check("R4 bcast default size", mem[10'h45], 32'd30);
      check_buf("R6 chain buffer", 10'h200, BCAST, 8'h40, 30);
      check("R4 bcast status", rx_status, 32'h0002_0001);

      wreg(4'd3, 32'h0);
      wreg(4'd2, 32'h200);
      w0 = wr_cnt;
      send(BCAST, 30, 8'h41);
      check("R4 bcast reject", rx_status, 32'h0002_0001);
      check("R11 bcast reject writes", wr_cnt, w0);
      send(MCAST, 16, 8'h60);
      check("R4 mcast kept size", mem[10'h49], 32'd16);
      check("R4 mcast status", rx_status, 32'h0003_0001);

      wreg(4'd2, 32'h300);
      w0 = wr_cnt;
      send(MCAST, 16, 8'h61);
      check("R4 mcast reject no ovf", rx_status, 32'h0003_0001);
      check("R11 mcast writes", wr_cnt, w0);

      wreg(4'd3, 32'h200);
      send(BCAST, 12, 8'h70);
      check("R7 overflow status", rx_status, 32'h0003_0005);
      check("R7 dma off", {31'h0, rx_dma_en}, 32'h0);
      check("R7 no writes", wr_cnt, w0);
      check("R7 buffer kept", mem[10'h100], exp_word(STA, 8'h10, 20, 0));

      wreg(4'd9, 32'h40);
      check("R10 ovf irq", {31'h0, irq}, 32'h1);
      wreg(4'd9, 32'h01);
      check("R10 tx masked off", {31'h0, irq}, 32'h0);
      @(negedge clk); tx_status = 4'h1; @(negedge clk);
      check("R10 tx irq", {31'h0, irq}, 32'h1);
      tx_status = 4'h0;
      wreg(4'd9, 32'h10);
      check("R10 rcv irq", {31'h0, irq}, 32'h1);
      wreg(4'd9, 32'h00);
      check("R10 mask zero", {31'h0, irq}, 32'h0);

      wreg(4'd8, 32'h4);
      check("R9 ovf clear", rx_status, 32'h0003_0001);
      wreg(4'd8, 32'h1);
      check("R9 dec", rx_status, 32'h0002_0001);
      wreg(4'd8, 32'h1);
      wreg(4'd8, 32'h1);
      check("R9 zero clears", rx_status, 32'h0);

      arm_ring();
      wreg(4'd7, 32'h100);
      wreg(4'd6, 32'h1);
      wreg(4'd2, 32'h0);
      wreg(4'd3, 32'h300);
      wreg(4'd1, 32'd23);
      send(STA, 24, 8'h80);
      check("R3 over limit", rx_status, 32'h0);
      send(STA, 23, 8'h55);
      check("R3 at limit size", mem[10'h41], 32'd23);
      check_buf("R6 zero fill", 10'h100, STA, 8'h55, 23);
      check("R3 at limit status", rx_status, 32'h0001_0001);
      send(STA, 5, 8'h00);
      check("R3 runt", rx_status, 32'h0001_0001);
      wreg(4'd1, 32'h600);
      send(STA, 257, 8'h90);
      check("R3 over buffer", rx_status, 32'h0001_0001);
      send(STA, 256, 8'h91);
      check("R3 full buffer size", mem[10'h45], 32'd256);
      check_buf("R3 full buffer data", 10'h200, STA, 8'h91, 256);
      check("R3 full buffer status", rx_status, 32'h0002_0001);

      wreg(4'd6, 32'h0);
      w0 = wr_cnt;
      send(STA, 20, 8'hA0);
      check("R2 dma off status", rx_status, 32'h0002_0001);
      check("R2 dma off writes", wr_cnt, w0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule